// File: doc/BRIEF.md
# Auto-Increment Control Register Bank

This block holds the byte-wide configuration registers of a multichannel audio converter. It sits behind a serial front end that has already framed the traffic into bytes. The front end gives the block a start strobe, a stop strobe, a read/write flag sampled with the start, and one strobe per byte. In a write transaction, the first byte is a map byte. Its top bit turns pointer stepping on or off, and its low seven bits select a register. Every later byte is written to the register the pointer selects. A read transaction has no map byte. It returns bytes starting from the pointer left by the last write transaction.

With stepping on, the pointer moves forward after every data byte, but only inside one of two sections. The first section covers registers 01h to 08h and the second covers 09h to 11h. At the top of either section the pointer stays where it is, so it never moves from the first section into the second.

Register 00h is a key register. Writing 99h to it opens access to a hidden register at 1Ah, and writing 00h to it closes that access again. Writing 80h to the hidden register turns the extended clocking modes on, and writing 00h turns them off. Closing access does not change the stored hidden value.

Top module: `ctl_regbank`

## Requirements
- R1: In a write transaction the first byte after the start strobe is the map byte: bit 7 is the stepping flag and bits 6:0 are the register pointer; nothing is written for it.
- R2: With the stepping flag 0, every data byte of a transaction (read or write) uses the same register.
- R3: With the stepping flag 1 and the pointer in 01h..07h, the pointer rises by one after each data byte; at 08h it stays at 08h and never becomes 09h.
- R4: With the stepping flag 1 and the pointer in 09h..10h, the pointer rises by one after each data byte; at 11h it stays at 11h.
- R5: A written byte appears on `cfgFlat` (register k at bits [8(k-1)+7 : 8(k-1)]) from the clock edge that samples its strobe. A read byte appears on `rdData` with `rdValid` high for one cycle after that same edge.
- R6: Writing 99h to 00h sets `hiddenOpen`; writing 00h to 00h clears it; any other value leaves it unchanged. Reads of 00h return 00h.
- R7: A write to 1Ah while `hiddenOpen` is high stores the byte, and a read then returns it. `extClkEn` is high exactly while the stored value is 80h.
- R8: While `hiddenOpen` is low, writes to 1Ah are ignored and reads of 1Ah return 00h.
- R9: Reset clears every register and the hidden value, closes access, and drives `extClkEn`, `rdValid` and `rdData` low.
- R10: Writes to addresses outside 00h..11h and 1Ah are ignored and reads from them return 00h; byte strobes outside a transaction change nothing.
- R11: A read transaction starts at the pointer and stepping flag left by the last map byte and steps by the rules of R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Transaction start strobe |
| frameStop | input | 1 | Transaction stop strobe |
| frameRead | input | 1 | Read transaction when high, sampled with frameStart |
| byteStb | input | 1 | One-cycle strobe for a framed byte |
| byteIn | input | 8 | Framed byte from the front end |
| rdData | output | 8 | Byte returned for a read strobe |
| rdValid | output | 1 | rdData valid |
| hiddenOpen | output | 1 | Hidden register access open |
| extClkEn | output | 1 | Extended clocking modes enabled |
| cfgFlat | output | 136 | Registers 01h..11h, packed |

## Verification
Some properties are checked on every cycle. These are: the pointer stays at 08h and at 11h on each data byte; read data follows every read strobe by exactly one cycle; the key values open access; a closed hidden register neither changes the mode output nor returns anything but zero. The sequences themselves can only be shown by the bench's scenarios. These include runs that cross a section top, read transactions that continue from a stored pointer, the full unlock, enable and relock order, and the effect of stray bytes on register contents. The bench shows them by comparing the packed registers and the read data against its own model.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam addr_t KEY_ADDR    = 7'h00;
  localparam addr_t SEC1_LO     = 7'h01;
  localparam addr_t SEC1_HI     = 7'h08;
  localparam addr_t SEC2_LO     = 7'h09;
  localparam addr_t SEC2_HI     = 7'h11;
  localparam addr_t HIDDEN_ADDR = 7'h1A;
  localparam byte_t KEY_OPEN    = 8'h99;
  localparam byte_t KEY_CLOSE   = 8'h00;
  localparam byte_t EXT_ON      = 8'h80;
  localparam int    NUM_REGS    = int'(SEC2_HI);

  typedef struct packed {
    logic  wrEn;
    logic  rdEn;
    addr_t addr;
    byte_t wdata;
  } strobes_t;
endpackage

// File: rtl/ctl_regbank_seq.sv
module ctl_regbank_seq
  import ctl_regbank_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStart,
  input  logic     frameStop,
  input  logic     frameRead,
  input  logic     byteStb,
  input  byte_t    byteIn,
  output strobes_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_MAP, ST_DATA} phase_t;

  phase_t phase;
  logic   readTx;
  logic   stepOn;
  addr_t  ptr;

  function automatic addr_t stepPtr(input addr_t p, input logic on);
    if (!on) return p;
    if (p >= SEC1_LO && p < SEC1_HI) return p + addr_t'(1);
    if (p >= SEC2_LO && p < SEC2_HI) return p + addr_t'(1);
    return p;
  endfunction

  logic byteLive;
  assign byteLive = byteStb && !frameStart && !frameStop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      readTx <= 1'b0;
      stepOn <= 1'b0;
      ptr    <= '0;
    end else if (frameStart) begin
      phase  <= frameRead ? ST_DATA : ST_MAP;
      readTx <= frameRead;
    end else if (frameStop) begin
      phase <= ST_IDLE;
    end else if (byteStb) begin
      case (phase)
        ST_MAP: begin
          ptr    <= byteIn[ADDR_W-1:0];
          stepOn <= byteIn[DATA_W-1];
          phase  <= ST_DATA;
        end
        ST_DATA: ptr <= stepPtr(ptr, stepOn);
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.wrEn  = byteLive && phase == ST_DATA && !readTx;
    strb.rdEn  = byteLive && phase == ST_DATA && readTx;
    strb.addr  = ptr;
    strb.wdata = byteIn;
  end
endmodule

// File: rtl/ctl_regbank_store.sv
module ctl_regbank_store
  import ctl_regbank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strb,
  output byte_t                      rdData,
  output logic                       rdValid,
  output logic                       hiddenOpen,
  output logic                       extClkEn,
  output logic [NUM_REGS*DATA_W-1:0] cfgFlat
);
  byte_t cfgReg [NUM_REGS];
  byte_t hiddenReg;
  byte_t readMux;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam addr_t MY_ADDR = addr_t'(k + 1);
    always_ff @(posedge clk) begin
      if (!rstN) cfgReg[k] <= '0;
      else if (strb.wrEn && strb.addr == MY_ADDR) cfgReg[k] <= strb.wdata;
    end
    assign cfgFlat[k*DATA_W +: DATA_W] = cfgReg[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiddenOpen <= 1'b0;
      hiddenReg  <= '0;
    end else if (strb.wrEn) begin
      if (strb.addr == KEY_ADDR) begin
        if (strb.wdata == KEY_OPEN) hiddenOpen <= 1'b1;
        else if (strb.wdata == KEY_CLOSE) hiddenOpen <= 1'b0;
      end
      if (strb.addr == HIDDEN_ADDR && hiddenOpen) hiddenReg <= strb.wdata;
    end
  end

  assign extClkEn = (hiddenReg == EXT_ON);

  always_comb begin
    readMux = '0;
    if (strb.addr >= SEC1_LO && strb.addr <= SEC2_HI)
      readMux = cfgReg[int'(strb.addr) - 1];
    else if (strb.addr == HIDDEN_ADDR && hiddenOpen)
      readMux = hiddenReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= readMux;
    end
  end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameStart,
  input  logic                       frameStop,
  input  logic                       frameRead,
  input  logic                       byteStb,
  input  logic [7:0]                 byteIn,
  output logic [7:0]                 rdData,
  output logic                       rdValid,
  output logic                       hiddenOpen,
  output logic                       extClkEn,
  output logic [NUM_REGS*DATA_W-1:0] cfgFlat
);
  strobes_t strb;

  ctl_regbank_seq u_seq (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameStop(frameStop),
    .frameRead(frameRead), .byteStb(byteStb), .byteIn(byteIn), .strb(strb)
  );

  ctl_regbank_store u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData), .rdValid(rdValid),
    .hiddenOpen(hiddenOpen), .extClkEn(extClkEn), .cfgFlat(cfgFlat)
  );
endmodule

// File: rtl/ctl_regbank_checker.sv
module ctl_regbank_checker
  import ctl_regbank_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input strobes_t strb,
  input byte_t    rdData,
  input logic     rdValid,
  input logic     hiddenOpen,
  input logic     extClkEn
);
  logic dataByte;
  assign dataByte = strb.wrEn || strb.rdEn;

  assert_sec1_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && strb.addr == SEC1_HI) |=> strb.addr == SEC1_HI);

  assert_sec2_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataByte && strb.addr == SEC2_HI) |=> strb.addr == SEC2_HI);

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> rdValid);

  assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> !rdValid);

  assert_key_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.addr == KEY_ADDR && strb.wdata == KEY_OPEN) |=> hiddenOpen);

  assert_locked_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.addr == HIDDEN_ADDR && !hiddenOpen) |=> $stable(extClkEn));

  assert_locked_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.addr == HIDDEN_ADDR && !hiddenOpen) |=> rdData == '0);
endmodule

bind ctl_regbank ctl_regbank_checker u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData), .rdValid(rdValid),
  .hiddenOpen(hiddenOpen), .extClkEn(extClkEn)
);

// File: tb/ctl_regbank_bench.sv
`timescale 1ns/1ps
module ctl_regbank_bench;
  localparam int NREG = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, frameStop = 1'b0, frameRead = 1'b0, byteStb = 1'b0;
  logic [7:0] byteIn = '0;
  logic [7:0] rdData;
  logic rdValid, hiddenOpen, extClkEn;
  logic [NREG*8-1:0] cfgFlat;

  always #2 clk = ~clk;

  ctl_regbank u_ctl_regbank (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameStop(frameStop),
    .frameRead(frameRead), .byteStb(byteStb), .byteIn(byteIn), .rdData(rdData),
    .rdValid(rdValid), .hiddenOpen(hiddenOpen), .extClkEn(extClkEn), .cfgFlat(cfgFlat)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [7:0] mReg [1:NREG];
  logic [7:0] mHidden;
  logic       mOpen, mStep, mRead;
  logic [6:0] mPtr;
  int         mPhase; // 0 idle, 1 map, 2 data

  function automatic logic [6:0] nextPtr(input logic [6:0] p, input logic on);
    if (!on) return p;
    if ((p >= 7'h01 && p < 7'h08) || (p >= 7'h09 && p < 7'h11)) return p + 7'd1;
    return p;
  endfunction

  function automatic logic [7:0] readModel(input logic [6:0] p);
    if (p >= 7'h01 && p <= 7'h11) return mReg[p];
    if (p == 7'h1A && mOpen) return mHidden;
    return 8'h00;
  endfunction

  function automatic string tagFor(input logic [6:0] p);
    if (p == 7'h00) return "R6";
    if (p >= 7'h01 && p <= 7'h08) return "R3";
    if (p >= 7'h09 && p <= 7'h11) return "R4";
    if (p == 7'h1A) return mOpen ? "R7" : "R8";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    for (int k = 1; k <= NREG; k++)
      check(req, 32'(cfgFlat[(k-1)*8 +: 8]), 32'(mReg[k]));
    check(req, 32'(hiddenOpen), 32'(mOpen));
    check(req, 32'(extClkEn), 32'(mHidden == 8'h80));
  endtask

  task automatic startTx(input logic rd);
    @(negedge clk); frameStart = 1'b1; frameRead = rd;
    @(negedge clk); frameStart = 1'b0;
    mRead = rd; mPhase = rd ? 2 : 1;
  endtask

  task automatic stopTx();
    @(negedge clk); frameStop = 1'b1;
    @(negedge clk); frameStop = 1'b0;
    mPhase = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, input string req);
    logic [6:0] p;
    logic [7:0] expRd;
    p = mPtr;
    expRd = readModel(p);
    @(negedge clk); byteStb = 1'b1; byteIn = b;
    @(negedge clk); byteStb = 1'b0;
    if (mPhase == 1) begin
      mPtr = b[6:0]; mStep = b[7]; mPhase = 2;
      checkState(req.len() ? req : "R1");
    end else if (mPhase == 2 && !mRead) begin
      if (p >= 7'h01 && p <= 7'h11) mReg[p] = b;
      else if (p == 7'h00) begin
        if (b == 8'h99) mOpen = 1'b1; else if (b == 8'h00) mOpen = 1'b0;
      end else if (p == 7'h1A && mOpen) mHidden = b;
      mPtr = nextPtr(p, mStep);
      checkState(req.len() ? req : tagFor(p));
      check("R5", 32'(rdValid), 32'd0);
    end else if (mPhase == 2) begin
      mPtr = nextPtr(p, mStep);
      check(req.len() ? req : "R11", 32'(rdValid), 32'd1);
      check(req.len() ? req : tagFor(p), 32'(rdData), 32'(expRd));
    end else begin
      checkState(req.len() ? req : "R10");
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected done");
    finish();
  end

  initial begin
    logic [6:0] picks [12];
    void'($urandom(32'h5EED));
    picks = '{7'h00, 7'h01, 7'h05, 7'h07, 7'h08, 7'h09, 7'h0F, 7'h10, 7'h11, 7'h1A, 7'h1E, 7'h64};
    for (int k = 1; k <= NREG; k++) mReg[k] = '0;
    mHidden = '0; mOpen = 0; mStep = 0; mRead = 0; mPtr = '0; mPhase = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R9");
    check("R9", 32'(rdValid), 32'd0);
    check("R9", 32'(rdData), 32'd0);

    // R3: run across the top of section one, stays at 08h
    startTx(0); sendByte(8'h86, "R1");
    for (int i = 0; i < 5; i++) sendByte(8'hA0 + 8'(i), "R3");
    stopTx();
    // R4: run across the top of section two
    startTx(0); sendByte(8'h8F, "R1");
    for (int i = 0; i < 5; i++) sendByte(8'h50 + 8'(i), "R4");
    stopTx();
    // R2: no stepping
    startTx(0); sendByte(8'h03, "R1");
    for (int i = 0; i < 3; i++) sendByte(8'h11 * 8'(i + 1), "R2");
    stopTx();
    // R11: read transaction continues from stored pointer, no stepping
    startTx(1); sendByte(8'h00, "R11"); sendByte(8'h00, "R11"); stopTx();
    // R8: locked hidden write and read
    startTx(0); sendByte(8'h1A, "R1"); sendByte(8'h80, "R8"); stopTx();
    startTx(1); sendByte(8'h00, "R8"); stopTx();
    // R6 / R7: unlock, enable, relock, read back
    startTx(0); sendByte(8'h00, "R1"); sendByte(8'h42, "R6"); sendByte(8'h99, "R6"); stopTx();
    startTx(0); sendByte(8'h1A, "R1"); sendByte(8'h80, "R7"); stopTx();
    startTx(1); sendByte(8'h00, "R7"); stopTx();
    startTx(0); sendByte(8'h00, "R1"); sendByte(8'h00, "R6"); stopTx();
    // R10: stray byte outside a transaction, unmapped write
    sendByte(8'hFF, "R10");
    startTx(0); sendByte(8'h20, "R1"); sendByte(8'h77, "R10"); stopTx();
    startTx(1); sendByte(8'h00, "R10"); stopTx();

    for (int t = 0; t < 400; t++) begin
      logic rd;
      logic [6:0] a;
      int len;
      rd = ($urandom % 3) == 0;
      len = 1 + ($urandom % 11);
      if (!rd) begin
        a = picks[$urandom % 12];
        startTx(0);
        sendByte({1'($urandom), a}, "");
        for (int i = 0; i < len; i++) begin
          logic [7:0] d;
          case ($urandom % 4)
            0: d = 8'h99;
            1: d = 8'h00;
            2: d = 8'h80;
            default: d = 8'($urandom);
          endcase
          sendByte(d, "");
        end
      end else begin
        startTx(1);
        for (int i = 0; i < len; i++) sendByte(8'($urandom), "");
      end
      stopTx();
    end
    finish();
  end
endmodule